// File: doc/BRIEF.md
# Four-Target Two-Bank Interrupt Router

This block gathers 64 interrupt lines, split into a legacy bank and an extended bank of 32 lines each. It routes them to four processor targets: three application cores (targets 0 to 2) and one IO/security core (target 3). Every line is taken as a rising-edge event. An edge latches a flag in that bank's status word of every target at once. Each target then clears its own copies by writing ones. A per-target mask for each bank picks which latched flags raise that target's interrupt line.

A second small register window serves older software. It holds one status/mask pair for the whole application cluster and one pair for the IO core, both fed by the legacy bank. It also holds a spare mask word. All registers sit in one 8-bit byte address space behind a simple word-wide register bus. A write is taken in the cycle `bus_wr` is high. Read data appears one cycle after `bus_rd`.

Top module: `irq_router`

## Requirements
- R1: After reset every status, mask and spare word reads 0x00000000, and all interrupt outputs are low.
- R2: A 0-to-1 change on `src_legacy[i]` sets bit i of the legacy status of all four targets and of both compatibility status words. A 0-to-1 change on `src_ext[i]` sets bit i of the extended status of all four targets. A line held high sets its bit only once.
- R3: A write to a status word clears every bit written as 1 and leaves the bits written as 0 unchanged. Clearing one target's copy leaves the other copies unchanged.
- R4: If a new rising edge arrives in the same cycle as a write of 1 that clears the same bit, the bit stays set.
- R5: Mask words are plain read/write and read back the last value written.
- R6: `irq_core[t]` is high exactly when, one clock earlier, target t had a bit set in both status and mask of either bank. Bits 0 to 2 serve the application cores and bit 3 serves the IO core.
- R7: Target t owns byte offsets 0x40+0x10·t (legacy status), +0x4 (extended status), +0x8 (legacy mask) and +0xC (extended mask).
- R8: The compatibility window sits at these offsets: 0x00 cluster status, 0x04 cluster mask, 0x08 IO status and 0x0C IO mask. The two status words follow R2 to R4 for the legacy bank. `irq_compat_app` and `irq_compat_io` follow their status/mask pair with the same one-clock delay as R6.
- R9: Offset 0x10 (spare mask) and offsets 0x80 and 0x84 (IO secondary masks, legacy and extended) are read/write and have no effect on any interrupt output.
- R10: Any other offset, including offsets not word-aligned, reads 0x00000000, and a write to it changes no register.
- R11: `bus_rdata` returns the addressed word in the cycle after `bus_rd` is high. It is 0x00000000 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_legacy | input | 32 | Legacy-bank interrupt lines |
| src_ext | input | 32 | Extended-bank interrupt lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_core | output | 4 | Per-target interrupt (3 = IO core) |
| irq_compat_app | output | 1 | Compatibility-window cluster interrupt |
| irq_compat_io | output | 1 | Compatibility-window IO-core interrupt |

## Verification
The assertions check four things on every cycle: that a latched edge survives its clock, that a cleared bit drops and other bits stay, that every interrupt output equals the previous cycle's status-and-mask reduction, and that read data is zero after idle cycles or unmapped reads. The bench's scenarios are needed to show the rest: the address map, the cross-target independence of clears, that a level held high does not re-arm after a clear, and that the spare and secondary masks leave every output untouched.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // compatibility window, byte offsets
  localparam int unsigned OFS_CPT_APP_ST = 'h00;
  localparam int unsigned OFS_CPT_APP_MK = 'h04;
  localparam int unsigned OFS_CPT_IO_ST  = 'h08;
  localparam int unsigned OFS_CPT_IO_MK  = 'h0C;
  localparam int unsigned OFS_CPT_SPARE  = 'h10;
  // per-target window: first 16-byte page of target 0
  localparam int unsigned CORE_PAGE      = 4;
  localparam int unsigned PAGE_BYTES     = 16;

  // word slot inside a target's page; order fixed by the map
  typedef enum logic [1:0] {
    SLOT_LEG_ST = 2'd0,
    SLOT_EXT_ST = 2'd1,
    SLOT_LEG_MK = 2'd2,
    SLOT_EXT_MK = 2'd3
  } slot_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic         armed_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  assign flags_o = flags_q;

  a_r2_edge_latched: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ((flags_q & $past(set_i)) == $past(set_i)));

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ((flags_q & $past(clr_i & ~set_i)) == '0));

  a_r3_others_kept: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (($past(flags_q) & ~$past(clr_i) & ~flags_q) == '0));
endmodule

// File: rtl/irq_word_reg.sv
module irq_word_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned BANK_W = 32,
  parameter int unsigned TGT_N  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] src_legacy,
  input  logic [BANK_W-1:0] src_ext,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic [TGT_N-1:0]  irq_core,
  output logic              irq_compat_app,
  output logic              irq_compat_io
);
  localparam int unsigned PG_W   = ADDR_W - 4;
  localparam int unsigned TIDX_W = (TGT_N > 1) ? $clog2(TGT_N) : 1;
  localparam logic [PG_W-1:0] PG_LO = PG_W'(CORE_PAGE);
  localparam logic [PG_W-1:0] PG_HI = PG_W'(CORE_PAGE + TGT_N);
  localparam logic [ADDR_W-1:0] AUX_LEG = ADDR_W'((CORE_PAGE + TGT_N) * PAGE_BYTES);
  localparam logic [ADDR_W-1:0] AUX_EXT = ADDR_W'((CORE_PAGE + TGT_N) * PAGE_BYTES + 4);

  // ---------------- address decode ----------------
  logic [PG_W-1:0]   page;
  logic [1:0]        slot;
  logic              aligned;
  logic              core_hit;
  logic [TIDX_W-1:0] tsel;

  assign page     = bus_addr[ADDR_W-1:4];
  assign slot     = bus_addr[3:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign core_hit = aligned && (page >= PG_LO) && (page < PG_HI);
  assign tsel     = TIDX_W'(page - PG_LO);

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // ---------------- source edges ----------------
  logic [BANK_W-1:0] leg_rise, ext_rise;

  irq_edge_detect #(.W(BANK_W)) u_leg_edge (
    .clk(clk), .rst(rst), .src_i(src_legacy), .rise_o(leg_rise));
  irq_edge_detect #(.W(BANK_W)) u_ext_edge (
    .clk(clk), .rst(rst), .src_i(src_ext), .rise_o(ext_rise));

  // ---------------- per-target register sets ----------------
  logic [BANK_W-1:0] leg_st [TGT_N];
  logic [BANK_W-1:0] ext_st [TGT_N];
  logic [BANK_W-1:0] leg_mk [TGT_N];
  logic [BANK_W-1:0] ext_mk [TGT_N];
  logic [TGT_N-1:0]  pending;

  for (genvar t = 0; t < TGT_N; t++) begin : g_tgt
    logic tgt_wr;
    assign tgt_wr = bus_wr && core_hit && (tsel == TIDX_W'(t));

    irq_flag_reg #(.W(BANK_W)) u_leg_st (
      .clk(clk), .rst(rst), .set_i(leg_rise),
      .clr_i((tgt_wr && slot == SLOT_LEG_ST) ? bus_wdata : '0),
      .flags_o(leg_st[t]));
    irq_flag_reg #(.W(BANK_W)) u_ext_st (
      .clk(clk), .rst(rst), .set_i(ext_rise),
      .clr_i((tgt_wr && slot == SLOT_EXT_ST) ? bus_wdata : '0),
      .flags_o(ext_st[t]));
    irq_word_reg #(.W(BANK_W)) u_leg_mk (
      .clk(clk), .rst(rst), .we_i(tgt_wr && slot == SLOT_LEG_MK),
      .d_i(bus_wdata), .q_o(leg_mk[t]));
    irq_word_reg #(.W(BANK_W)) u_ext_mk (
      .clk(clk), .rst(rst), .we_i(tgt_wr && slot == SLOT_EXT_MK),
      .d_i(bus_wdata), .q_o(ext_mk[t]));

    assign pending[t] = |(leg_st[t] & leg_mk[t]) | |(ext_st[t] & ext_mk[t]);
  end

  // ---------------- compatibility window ----------------
  logic [BANK_W-1:0] cpt_app_st, cpt_app_mk, cpt_io_st, cpt_io_mk, cpt_spare;
  logic [BANK_W-1:0] aux_leg_mk, aux_ext_mk;

  irq_flag_reg #(.W(BANK_W)) u_cpt_app_st (
    .clk(clk), .rst(rst), .set_i(leg_rise),
    .clr_i((bus_wr && at(bus_addr, OFS_CPT_APP_ST)) ? bus_wdata : '0),
    .flags_o(cpt_app_st));
  irq_flag_reg #(.W(BANK_W)) u_cpt_io_st (
    .clk(clk), .rst(rst), .set_i(leg_rise),
    .clr_i((bus_wr && at(bus_addr, OFS_CPT_IO_ST)) ? bus_wdata : '0),
    .flags_o(cpt_io_st));
  irq_word_reg #(.W(BANK_W)) u_cpt_app_mk (
    .clk(clk), .rst(rst), .we_i(bus_wr && at(bus_addr, OFS_CPT_APP_MK)),
    .d_i(bus_wdata), .q_o(cpt_app_mk));
  irq_word_reg #(.W(BANK_W)) u_cpt_io_mk (
    .clk(clk), .rst(rst), .we_i(bus_wr && at(bus_addr, OFS_CPT_IO_MK)),
    .d_i(bus_wdata), .q_o(cpt_io_mk));
  irq_word_reg #(.W(BANK_W)) u_cpt_spare (
    .clk(clk), .rst(rst), .we_i(bus_wr && at(bus_addr, OFS_CPT_SPARE)),
    .d_i(bus_wdata), .q_o(cpt_spare));
  irq_word_reg #(.W(BANK_W)) u_aux_leg (
    .clk(clk), .rst(rst), .we_i(bus_wr && bus_addr == AUX_LEG),
    .d_i(bus_wdata), .q_o(aux_leg_mk));
  irq_word_reg #(.W(BANK_W)) u_aux_ext (
    .clk(clk), .rst(rst), .we_i(bus_wr && bus_addr == AUX_EXT),
    .d_i(bus_wdata), .q_o(aux_ext_mk));

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_core       <= '0;
      irq_compat_app <= 1'b0;
      irq_compat_io  <= 1'b0;
    end else begin
      irq_core       <= pending;
      irq_compat_app <= |(cpt_app_st & cpt_app_mk);
      irq_compat_io  <= |(cpt_io_st & cpt_io_mk);
    end
  end

  // ---------------- read path ----------------
  logic [BANK_W-1:0] rd_val;
  logic              rd_hit;

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    if (core_hit) begin
      rd_hit = 1'b1;
      unique case (slot)
        SLOT_LEG_ST: rd_val = leg_st[tsel];
        SLOT_EXT_ST: rd_val = ext_st[tsel];
        SLOT_LEG_MK: rd_val = leg_mk[tsel];
        default:     rd_val = ext_mk[tsel];
      endcase
    end else begin
      rd_hit = 1'b1;
      if      (at(bus_addr, OFS_CPT_APP_ST)) rd_val = cpt_app_st;
      else if (at(bus_addr, OFS_CPT_APP_MK)) rd_val = cpt_app_mk;
      else if (at(bus_addr, OFS_CPT_IO_ST))  rd_val = cpt_io_st;
      else if (at(bus_addr, OFS_CPT_IO_MK))  rd_val = cpt_io_mk;
      else if (at(bus_addr, OFS_CPT_SPARE))  rd_val = cpt_spare;
      else if (bus_addr == AUX_LEG)          rd_val = aux_leg_mk;
      else if (bus_addr == AUX_EXT)          rd_val = aux_ext_mk;
      else                                   rd_hit = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  // ---------------- assertions ----------------
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  for (genvar t = 0; t < TGT_N; t++) begin : g_chk
    a_r6_irq_follows: assert property (@(posedge clk) disable iff (rst)
      armed_q |-> (irq_core[t] == ($past(|(leg_st[t] & leg_mk[t])) ||
                                   $past(|(ext_st[t] & ext_mk[t])))));
  end

  a_r8_compat_app: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (irq_compat_app == $past(|(cpt_app_st & cpt_app_mk))));

  a_r8_compat_io: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (irq_compat_io == $past(|(cpt_io_st & cpt_io_mk))));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && !rd_hit) |-> (bus_rdata == '0));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_legacy = '0, src_ext = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_core;
  logic        irq_compat_app, irq_compat_io;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router uut (
    .clk(clk), .rst(rst), .src_legacy(src_legacy), .src_ext(src_ext),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_core(irq_core),
    .irq_compat_app(irq_compat_app), .irq_compat_io(irq_compat_io));

  // ---------------- reference model from the requirements ----------------
  logic [31:0] m_ls [4], m_es [4], m_lm [4], m_em [4];
  logic [31:0] m_cas, m_cam, m_cis, m_cim, m_spare, m_aux0, m_aux1;
  logic [31:0] m_prev_l, m_prev_e;

  task automatic model_reset();
    for (int t = 0; t < 4; t++) begin
      m_ls[t] = '0; m_es[t] = '0; m_lm[t] = '0; m_em[t] = '0;
    end
    m_cas = '0; m_cam = '0; m_cis = '0; m_cim = '0;
    m_spare = '0; m_aux0 = '0; m_aux1 = '0;
    m_prev_l = '0; m_prev_e = '0;
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a)
      8'h00: return m_cas;
      8'h04: return m_cam;
      8'h08: return m_cis;
      8'h0C: return m_cim;
      8'h10: return m_spare;
      8'h80: return m_aux0;
      8'h84: return m_aux1;
      default: ;
    endcase
    if (a >= 8'h40 && a < 8'h80) begin
      int t = int'((a - 8'h40) >> 4);
      case (a[3:2])
        2'd0: return m_ls[t];
        2'd1: return m_es[t];
        2'd2: return m_lm[t];
        default: return m_em[t];
      endcase
    end
    return '0;
  endfunction

  task automatic model_edge(input logic wr, input logic [7:0] a,
                            input logic [31:0] d, input logic [31:0] sl,
                            input logic [31:0] se);
    logic [31:0] rl, re;
    rl = sl & ~m_prev_l;
    re = se & ~m_prev_e;
    m_prev_l = sl;
    m_prev_e = se;
    for (int t = 0; t < 4; t++) begin
      logic [7:0] b;
      b = 8'h40 + 8'(16 * t);
      m_ls[t] = (m_ls[t] & ~((wr && a == b)        ? d : 32'h0)) | rl;
      m_es[t] = (m_es[t] & ~((wr && a == b + 8'h4) ? d : 32'h0)) | re;
      if (wr && a == b + 8'h8) m_lm[t] = d;
      if (wr && a == b + 8'hC) m_em[t] = d;
    end
    m_cas = (m_cas & ~((wr && a == 8'h00) ? d : 32'h0)) | rl;
    m_cis = (m_cis & ~((wr && a == 8'h08) ? d : 32'h0)) | rl;
    if (wr && a == 8'h04) m_cam = d;
    if (wr && a == 8'h0C) m_cim = d;
    if (wr && a == 8'h10) m_spare = d;
    if (wr && a == 8'h80) m_aux0 = d;
    if (wr && a == 8'h84) m_aux1 = d;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] sl,
                      input logic [31:0] se, input string tag);
    logic [31:0] exp_rd;
    logic [3:0]  exp_irq;
    logic        exp_ca, exp_ci;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    src_legacy = sl; src_ext = se;
    @(posedge clk);
    for (int t = 0; t < 4; t++)
      exp_irq[t] = |(m_ls[t] & m_lm[t]) | |(m_es[t] & m_em[t]);
    exp_ca = |(m_cas & m_cam);
    exp_ci = |(m_cis & m_cim);
    exp_rd = rd ? model_read(a) : 32'h0;
    model_edge(wr, a, d, sl, se);
    @(negedge clk);
    chk(rd ? tag : "R11", $sformatf("rdata @%h", a), bus_rdata, exp_rd);
    chk("R6", "irq_core", {28'h0, irq_core}, {28'h0, exp_irq});
    chk("R8", "compat irqs", {30'h0, irq_compat_app, irq_compat_io},
        {30'h0, exp_ca, exp_ci});
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, src_legacy, src_ext, tag);
  endtask

  task automatic rd32(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, a, 32'h0, src_legacy, src_ext, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h0, 32'h0, src_legacy, src_ext, "R11");
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 26)
      0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
      4: return 8'h10;  5: return 8'h80;  6: return 8'h84;  7: return 8'h20;
      8: return 8'h42;  9: return 8'h90;
      default: return 8'h40 + 8'(((r % 26) - 10) * 4);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd32(8'h40, "R1"); rd32(8'h74, "R1"); rd32(8'h00, "R1"); rd32(8'h0C, "R1");
    chk("R1", "irq_core after reset", {28'h0, irq_core}, 32'h0);

    // R5, R7: each target's masks at their own offsets
    for (int t = 0; t < 4; t++) begin
      wr32(8'h48 + 8'(16 * t), 32'h1111_0000 * (t + 1), "R5");
      wr32(8'h4C + 8'(16 * t), 32'h0000_00A5 << t, "R5");
    end
    for (int t = 0; t < 4; t++) begin
      rd32(8'h48 + 8'(16 * t), "R7");
      rd32(8'h4C + 8'(16 * t), "R7");
    end

    // clear masks, then R2: legacy edge on bit 5 reaches every copy
    for (int t = 0; t < 4; t++) begin
      wr32(8'h48 + 8'(16 * t), 32'h0, "R5");
      wr32(8'h4C + 8'(16 * t), 32'h0, "R5");
    end
    step(1'b0, 1'b0, 8'h0, 32'h0, 32'h0000_0020, 32'h8000_0000, "R2");
    for (int t = 0; t < 4; t++) begin
      rd32(8'h40 + 8'(16 * t), "R2");
      rd32(8'h44 + 8'(16 * t), "R2");
    end
    rd32(8'h00, "R2"); rd32(8'h08, "R2");

    // R3: clear target 1 only, held level must not re-set
    wr32(8'h50, 32'h0000_0020, "R3");
    idle(2);
    rd32(8'h50, "R3"); rd32(8'h40, "R3"); rd32(8'h60, "R3");
    wr32(8'h44, 32'h0000_0000, "R3");
    rd32(8'h44, "R3");

    // R6: enabling a mask on a latched flag raises only that target
    wr32(8'h78, 32'h0000_0020, "R6");
    idle(1);
    wr32(8'h78, 32'h0, "R6");
    wr32(8'h5C, 32'h8000_0000, "R6");
    idle(1);

    // R4: new edge while clearing the same bit keeps it set
    step(1'b0, 1'b0, 8'h0, 32'h0, 32'h0, 32'h0, "R4");
    step(1'b1, 1'b0, 8'h60, 32'h0000_0020, 32'h0000_0020, 32'h0, "R4");
    rd32(8'h60, "R4");

    // R8: compatibility pair drives its own outputs
    wr32(8'h04, 32'h0000_0020, "R8");
    wr32(8'h0C, 32'h0000_0020, "R8");
    idle(1);
    wr32(8'h00, 32'hFFFF_FFFF, "R8");
    idle(1);

    // R9: spare and secondary masks have no effect on outputs
    wr32(8'h10, 32'hFFFF_FFFF, "R9");
    wr32(8'h80, 32'hFFFF_FFFF, "R9");
    wr32(8'h84, 32'hFFFF_FFFF, "R9");
    idle(2);
    rd32(8'h10, "R9"); rd32(8'h80, "R9"); rd32(8'h84, "R9");

    // R10: unmapped and unaligned offsets
    wr32(8'h20, 32'hDEAD_BEEF, "R10");
    wr32(8'h4A, 32'hFFFF_FFFF, "R10");
    wr32(8'hF0, 32'h1234_5678, "R10");
    rd32(8'h20, "R10"); rd32(8'h4A, "R10"); rd32(8'hF0, "R10");
    rd32(8'h48, "R10"); rd32(8'h40, "R10");

    // random traffic checked against the model
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      logic [31:0] sl, se;
      r  = $urandom;
      sl = src_legacy ^ ($urandom & $urandom & $urandom);
      se = src_ext ^ ($urandom & $urandom & $urandom);
      case (r % 4)
        0, 1: step(1'b0, 1'b1, pick_addr($urandom), 32'h0, sl, se, "R7");
        2:    step(1'b1, 1'b0, pick_addr($urandom), $urandom, sl, se, "R3");
        default: step(1'b0, 1'b0, 8'h0, 32'h0, sl, se, "R2");
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule